// File: doc/BRIEF.md
# UART Line Status Register Logic

This block holds the receive and transmit status of a memory-mapped UART and presents it as one 16-bit read-only status word. The receiver reports events as single-cycle pulses: a word has been loaded, a parity error, a framing error (the stop bit was sampled low), and a break (the serial input stayed low for longer than one maximum-length character frame). The transmitter reports two levels: its holding register is empty, and its shift register is empty. The bus side supplies two read strobes, one for the status word and one for the receive data register.

The error flags are sticky. A read of the status word clears them as a side effect. The value returned by that read still shows them set, and they drop on the following cycle. The data-ready flag is different: only a read of the receive data register clears it. Overrun is detected inside the block. It is raised when a new word arrives while earlier data is still unread. When a set event and a clearing read fall in the same cycle, the set wins. The transmit flags are registered copies of the transmitter levels.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word reads 0x0060: bits 6 and 5 set, all other bits clear.
- R2: Bits 15 down to 7 of the status word always read as zero.
- R3: Bit 5 (holding empty) equals the `txHoldEmpty` input sampled on the previous clock edge, whatever the shift register state.
- R4: Bit 6 (transmitter idle) is 1 only when both `txHoldEmpty` and `txShiftEmpty` were 1 on the previous clock edge.
- R5: A one-cycle pulse on `rxBreak`, `rxFrameErr` or `rxParityErr` sets bit 4, bit 3 or bit 2 respectively from the next cycle. The bit stays set until a status read.
- R6: In the cycle `statusRdStrb` is high, the status word still shows the error bits 4..1. In the next cycle those bits are clear, unless a new event set them.
- R7: A pulse on `rxWordStrb` while bit 0 is set, with no `dataRdStrb` in that cycle, sets bit 1 (overrun) from the next cycle. Bit 1 is cleared only by a status read.
- R8: Bit 0 (data ready) sets the cycle after `rxWordStrb`. It clears the cycle after `dataRdStrb`. A status read leaves it unchanged.
- R9: A set event in the same cycle as its clearing read leaves the flag set: an error pulse beats `statusRdStrb`, and `rxWordStrb` beats `dataRdStrb`.
- R10: When `rxWordStrb` and `dataRdStrb` are high in the same cycle while bit 0 is set, no overrun is flagged and bit 0 stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxWordStrb | input | 1 | Pulse: receiver loaded a new word |
| rxParityErr | input | 1 | Pulse: parity mismatch on a received word |
| rxFrameErr | input | 1 | Pulse: stop bit sampled low |
| rxBreak | input | 1 | Pulse: line held low beyond a full frame |
| txHoldEmpty | input | 1 | Level: transmit holding register empty |
| txShiftEmpty | input | 1 | Level: transmit shift register empty |
| statusRdStrb | input | 1 | Bus read of the status word |
| dataRdStrb | input | 1 | Bus read of the receive data register |
| statusWord | output | 16 | Assembled status word |

## Verification
The hardest cases to reach are the coincidences: a clearing read in exactly the same cycle as a new event that sets the same flag, and a new received word that arrives in the very cycle its predecessor is read out. Directed tasks line these up cycle by cycle. They first put the flag into a known state. They then raise the set pulse and the read strobe together for one cycle. They inspect the word both during the read cycle and after it, so the set-wins rule and the missing overrun show up at the ports.

// File: rtl/uls_pkg.sv
package uls_pkg;
  // number of sticky error flags (overrun, parity, framing, break)
  localparam int NUM_ERR = 4;
  // index of each error inside the sticky error vector
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;

  typedef struct packed {
    logic [NUM_ERR-1:0] setErr;
    logic               clrErr;
    logic               setDr;
    logic               clrDr;
  } ulsStrb_t;
endpackage

// File: rtl/uls_ctrl.sv
module uls_ctrl
  import uls_pkg::*;
(
  input  logic     rxWordStrb,
  input  logic     rxParityErr,
  input  logic     rxFrameErr,
  input  logic     rxBreak,
  input  logic     statusRdStrb,
  input  logic     dataRdStrb,
  input  logic     drNow,
  output ulsStrb_t strb
);
  logic overrunHit;

  // a new word overwrites unread data unless that data is read this cycle
  always_comb begin
    overrunHit = rxWordStrb & drNow & ~dataRdStrb;
  end

  always_comb begin
    strb                 = '0;
    strb.setErr[ERR_OVR] = overrunHit;
    strb.setErr[ERR_PAR] = rxParityErr;
    strb.setErr[ERR_FRM] = rxFrameErr;
    strb.setErr[ERR_BRK] = rxBreak;
    strb.clrErr          = statusRdStrb;
    strb.setDr           = rxWordStrb;
    strb.clrDr           = dataRdStrb;
  end
endmodule

// File: rtl/uls_dpath.sv
module uls_dpath
  import uls_pkg::*;
#(
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ulsStrb_t            strb,
  input  logic                txHoldEmpty,
  input  logic                txShiftEmpty,
  output logic                drNow,
  output logic [STATUS_W-1:0] statusWord
);
  localparam int DR_BIT   = 0;
  localparam int ERR_LSB  = DR_BIT + 1;
  localparam int HOLD_BIT = ERR_LSB + NUM_ERR;
  localparam int IDLE_BIT = HOLD_BIT + 1;
  localparam int USED_W   = IDLE_BIT + 1;

  logic               drQ;
  logic [NUM_ERR-1:0] errQ;
  logic               holdQ;
  logic               idleQ;

  // data ready: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            drQ <= 1'b0;
    else if (strb.setDr)  drQ <= 1'b1;
    else if (strb.clrDr)  drQ <= 1'b0;
  end

  // sticky error flags, one register per flag
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errQ[i] <= 1'b0;
      else       errQ[i] <= strb.setErr[i] | (errQ[i] & ~strb.clrErr);
    end
  end

  // transmit side mirrors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b1;
      idleQ <= 1'b1;
    end else begin
      holdQ <= txHoldEmpty;
      idleQ <= txHoldEmpty & txShiftEmpty;
    end
  end

  always_comb begin
    statusWord                       = '0;
    statusWord[DR_BIT]               = drQ;
    statusWord[ERR_LSB +: NUM_ERR]   = errQ;
    statusWord[HOLD_BIT]             = holdQ;
    statusWord[IDLE_BIT]             = idleQ;
  end

  assign drNow = drQ;

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrErr |=> ((errQ & $past(errQ)) == $past(errQ)));

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrErr |=> (errQ == $past(strb.setErr)));

  // R9
  err_setwins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setErr) |=> ((errQ & $past(strb.setErr)) == $past(strb.setErr)));

  // R8
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drQ && !strb.clrDr) |=> drQ);

  // R9
  dr_setwins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDr |=> drQ);

  // R2
  always_comb begin
    reserved_zero_chk: assert (statusWord[STATUS_W-1:USED_W] == '0);
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxWordStrb,
  input  logic                rxParityErr,
  input  logic                rxFrameErr,
  input  logic                rxBreak,
  input  logic                txHoldEmpty,
  input  logic                txShiftEmpty,
  input  logic                statusRdStrb,
  input  logic                dataRdStrb,
  output logic [STATUS_W-1:0] statusWord
);
  ulsStrb_t strb;
  logic     drNow;

  uls_ctrl u_ctrl (
    .rxWordStrb   (rxWordStrb),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr),
    .rxBreak      (rxBreak),
    .statusRdStrb (statusRdStrb),
    .dataRdStrb   (dataRdStrb),
    .drNow        (drNow),
    .strb         (strb)
  );

  uls_dpath #(.STATUS_W(STATUS_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .txHoldEmpty  (txHoldEmpty),
    .txShiftEmpty (txShiftEmpty),
    .drNow        (drNow),
    .statusWord   (statusWord)
  );

  // R7
  overrun_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxWordStrb && statusWord[0] && !dataRdStrb) |=> statusWord[1]);

  // R10
  read_and_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxWordStrb && dataRdStrb && statusWord[0] && !statusWord[1])
      |=> (statusWord[0] && !statusWord[1]));

  // R3
  hold_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[5] == $past(txHoldEmpty)));

  // R4
  idle_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusWord[6] == ($past(txHoldEmpty) && $past(txShiftEmpty))));
endmodule

// File: tb/sim_uart_line_status.sv
`timescale 1ns/1ps
module sim_uart_line_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxWordStrb = 0, rxParityErr = 0, rxFrameErr = 0, rxBreak = 0;
  logic        txHoldEmpty = 1, txShiftEmpty = 1;
  logic        statusRdStrb = 0, dataRdStrb = 0;
  logic [15:0] statusWord;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  uart_line_status u0 (
    .clk(clk), .rstN(rstN),
    .rxWordStrb(rxWordStrb), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .statusRdStrb(statusRdStrb), .dataRdStrb(dataRdStrb),
    .statusWord(statusWord)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(statusWord, 16'h0060, "R1 reset value");
    check({7'd0, statusWord[15:7]}, 16'h0000, "R2 reserved bits");
  endtask

  task automatic t_tx();
    txHoldEmpty = 0; txShiftEmpty = 0; cyc();
    check(statusWord, 16'h0000, "R3/R4 byte written");
    txHoldEmpty = 1; cyc();
    check(statusWord, 16'h0020, "R3 hold empty, shifter busy");
    check({15'd0, statusWord[6]}, 16'h0000, "R4 idle needs both");
    txShiftEmpty = 1; cyc();
    check(statusWord, 16'h0060, "R4 both empty");
  endtask

  task automatic t_errors();
    rxParityErr = 1; cyc(); rxParityErr = 0;
    check(statusWord, 16'h0064, "R5 parity sets bit 2");
    cyc(); cyc();
    check(statusWord, 16'h0064, "R5 parity sticky");
    rxFrameErr = 1; cyc(); rxFrameErr = 0;
    check(statusWord, 16'h006C, "R5 framing sets bit 3");
    rxBreak = 1; cyc(); rxBreak = 0;
    check(statusWord, 16'h007C, "R5 break sets bit 4");
    statusRdStrb = 1; #1;
    check(statusWord, 16'h007C, "R6 read cycle still shows errors");
    cyc(); statusRdStrb = 0;
    check(statusWord, 16'h0060, "R6 errors cleared after read");
    check({7'd0, statusWord[15:7]}, 16'h0000, "R2 reserved after read");
  endtask

  task automatic t_data();
    rxWordStrb = 1; cyc(); rxWordStrb = 0;
    check(statusWord, 16'h0061, "R8 data ready set");
    statusRdStrb = 1; cyc(); statusRdStrb = 0;
    check(statusWord, 16'h0061, "R8 status read keeps data ready");
    rxWordStrb = 1; cyc(); rxWordStrb = 0;
    check(statusWord, 16'h0063, "R7 overrun flagged");
    dataRdStrb = 1; cyc(); dataRdStrb = 0;
    check(statusWord, 16'h0062, "R8 data read clears bit 0, R7 overrun stays");
    statusRdStrb = 1; cyc(); statusRdStrb = 0;
    check(statusWord, 16'h0060, "R7 overrun cleared by status read");
    rxWordStrb = 1; cyc(); rxWordStrb = 0;
    check(statusWord, 16'h0061, "R7 no overrun when empty");
    dataRdStrb = 1; cyc(); dataRdStrb = 0;
    check(statusWord, 16'h0060, "R8 cleared");
  endtask

  task automatic t_coincide();
    rxParityErr = 1; cyc(); rxParityErr = 0;
    check(statusWord, 16'h0064, "R9 parity preset");
    statusRdStrb = 1; rxParityErr = 1; cyc(); statusRdStrb = 0; rxParityErr = 0;
    check(statusWord, 16'h0064, "R9 new parity beats status read");
    statusRdStrb = 1; rxFrameErr = 1; cyc(); statusRdStrb = 0; rxFrameErr = 0;
    check(statusWord, 16'h0068, "R9 read clears old, keeps new framing");
    statusRdStrb = 1; cyc(); statusRdStrb = 0;
    check(statusWord, 16'h0060, "R6 clean");
    rxWordStrb = 1; dataRdStrb = 1; cyc(); rxWordStrb = 0; dataRdStrb = 0;
    check(statusWord, 16'h0061, "R9 word beats data read when empty");
    rxWordStrb = 1; dataRdStrb = 1; cyc(); rxWordStrb = 0; dataRdStrb = 0;
    check(statusWord, 16'h0061, "R10 read and load same cycle, no overrun");
    dataRdStrb = 1; cyc(); dataRdStrb = 0;
    check(statusWord, 16'h0060, "R8 final clear");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    t_reset();
    t_tx();
    t_errors();
    t_data();
    t_coincide();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule